// File: doc/BRIEF.md
# Debug Register-to-AHB Access Bridge

This block sits on the debug side of a chip and turns accesses on a small register port into single AHB master transfers. The register port has a select, a write strobe, an address, write data, read data and a ready return. Behind it are the following registers:

- a control/status word that sets the transfer size and the address-increment policy;
- a transfer address register;
- a data register, whose access launches a bus transfer;
- four banked data windows, which reach the sixteen-byte group that the transfer address points into;
- two fixed read-only words.

A write to the data register or to a banked window produces one AHB write, and a read produces one AHB read. The port holds ready low until the bus data phase has finished. Byte and halfword accesses are moved to and from the byte lanes that the low address bits select. An external enable input decides whether any bus traffic is allowed at all. After an error-free transfer through the data register, the address can step forward by the access size, staying inside the current 4 KB page. An error response is kept in a sticky status bit until software clears it.

The port handles one access at a time. The host keeps select high until it sees ready, then drops it for at least one cycle.

Top module: `dbg_ahb_bridge`

## Requirements
- R1: Register offsets: control/status 0x00, transfer address 0x04, data 0x0C, banked windows 0x10/0x14/0x18/0x1C, fixed word 0xE00FF003 at 0xF8, fixed word 0x24770011 at 0xFC. Writes to the fixed words have no effect, and every other offset reads zero.
- R2: Control/status layout:
  - bit 29 is the master-type bit, reset 1;
  - bit 25 is the privilege bit, reset 1;
  - bit 24 always reads 1;
  - bits [11:8] are a mode field, reset 0;
  - bit 7 is the busy flag;
  - bit 6 mirrors the enable input;
  - bits [5:4] are the increment mode, reset 00;
  - bit 3 is the sticky error bit;
  - bits [2:0] are the size, reset 000.

  Bits [31:30], [28:26] and [23:12] read 0. After reset with the enable input high, the word reads 0x23000040.
- R3: A data-register access issues exactly one transfer with HTRANS NONSEQ (10), HBURST SINGLE (000), HADDR equal to the transfer address, HSIZE equal to the size field, and HWRITE set for a write. The address is held while HREADY is low.
- R4: For writes, 8-bit data (size 000) is placed on byte lane addr[1:0]; 16-bit data (size 001) is placed on halfword lane addr[1]; 32-bit data (size 010) is passed unchanged. Unused lanes are zero.
- R5: For reads, the selected byte or halfword lane is returned right-aligned and zero-extended.
- R6: With increment mode 01, the transfer address grows by 1, 2 or 4 (following the size) after each error-free data-register transfer. Mode 10 steps the same way, since no packing is done. Mode 00 leaves the address unchanged.
- R7: Increments wrap within the 4 KB page: address bits [31:12] never change except by a write to the transfer address register.
- R8: An error response (HRESP=1 with HREADY=1 in the data phase) sets the error bit and suppresses the increment; a read that ends in error returns zero. Writing the control/status word with bit 3 set clears the error bit.
- R9: Banked window k (offset 0x10+4k) accesses address {transfer address[31:4], k, 2'b00} and never changes the transfer address.
- R10: With the enable input low, data and banked accesses issue no transfer, complete with ready, and reads return zero; bit 6 reads 0.
- R11: Increment mode 11 or a size code from 011 to 111 suppresses the transfer; such reads return zero.
- R12: Ready is a one-cycle pulse. It comes one cycle after acceptance for register-only accesses and for suppressed transfers. For a bus transfer it comes three cycles after acceptance plus one cycle per data-phase wait state, and it is never high while an address phase is on the bus.
- R13: HPROT equals {2'b00, privilege bit, 1'b1}, and the debug-master output follows bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Permission for bus traffic |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_ready |
| reg_ready | output | 1 | Access complete pulse |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB write flag |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hprot | output | 4 | AHB protection |
| hdebug | output | 1 | Master type: 1 debug, 0 core |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done |
| hresp | input | 1 | AHB error response |

## Verification
The properties rely on four things about the environment:

- the host keeps select high until ready and then lowers it;
- the enable input changes only when no access is in flight;
- the slave keeps HREADY high outside a data phase;
- the slave signals an error only in the single cycle that HREADY closes the data phase.

The stimulus meets these conditions. Each access is one task call that waits for ready and drops select on that same cycle. The enable input is changed only between calls. The slave model inserts wait states and errors only during data phases.

// File: rtl/dbgab_pkg.sv
package dbgab_pkg;

    localparam int unsigned BUS_W = 32;

    localparam logic [7:0] OFS_CSW  = 8'h00;
    localparam logic [7:0] OFS_TAR  = 8'h04;
    localparam logic [7:0] OFS_DATA = 8'h0C;
    localparam logic [7:0] OFS_ROM  = 8'hF8;
    localparam logic [7:0] OFS_ID   = 8'hFC;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [2:0] HB_SINGLE = 3'b000;
    localparam logic [2:0] SZ_MAX    = 3'b010;

    typedef enum logic [1:0] {
        INC_OFF    = 2'b00,
        INC_SINGLE = 2'b01,
        INC_PACKED = 2'b10,
        INC_RSVD   = 2'b11
    } inc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } xfer_st_e;

    typedef struct packed {
        logic       mtype;
        logic       priv;
        logic [3:0] mode;
        inc_e       inc;
        logic       err;
        logic [2:0] size;
    } ctl_t;

    // Byte/halfword placement on the write lanes.
    function automatic logic [BUS_W-1:0] place_lanes(input logic [BUS_W-1:0] d,
                                                     input logic [1:0] a,
                                                     input logic [2:0] sz);
        logic [BUS_W-1:0] r;
        case (sz)
            3'b000:  r = {24'b0, d[7:0]} << {a, 3'b000};
            3'b001:  r = {16'b0, d[15:0]} << {a[1], 4'b0000};
            default: r = d;
        endcase
        return r;
    endfunction

    // Right-aligned extraction from the read lanes.
    function automatic logic [BUS_W-1:0] pick_lanes(input logic [BUS_W-1:0] d,
                                                    input logic [1:0] a,
                                                    input logic [2:0] sz);
        logic [BUS_W-1:0] s;
        logic [BUS_W-1:0] r;
        case (sz)
            3'b000: begin
                s = d >> {a, 3'b000};
                r = {24'b0, s[7:0]};
            end
            3'b001: begin
                s = d >> {a[1], 4'b0000};
                r = {16'b0, s[15:0]};
            end
            default: begin
                s = d;
                r = s;
            end
        endcase
        return r;
    endfunction

    // Step within the 4 KB page; upper bits are carried unchanged.
    function automatic logic [BUS_W-1:0] page_step(input logic [BUS_W-1:0] a,
                                                   input logic [2:0] sz);
        logic [11:0] inc;
        case (sz)
            3'b000:  inc = 12'd1;
            3'b001:  inc = 12'd2;
            default: inc = 12'd4;
        endcase
        return {a[BUS_W-1:12], a[11:0] + inc};
    endfunction

    function automatic logic [BUS_W-1:0] csw_word(input ctl_t c, input logic busy,
                                                  input logic en);
        return {2'b00, c.mtype, 3'b000, c.priv, 1'b1, 12'h000, c.mode,
                busy, en, c.inc, c.err, c.size};
    endfunction

endpackage

// File: rtl/dbgab_regs.sv
module dbgab_regs
    import dbgab_pkg::*;
#(
    parameter int          REG_AW   = 8,
    parameter logic [31:0] ROM_WORD = 32'hE00F_F003,
    parameter logic [31:0] ID_WORD  = 32'h2477_0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              busy,
    input  logic              dbg_en,
    input  logic              tar_step,
    input  logic              err_set,
    output logic              out_mtype,
    output logic              out_priv,
    output inc_e              out_inc,
    output logic [2:0]        out_size,
    output logic [BUS_W-1:0]  tar,
    output logic [BUS_W-1:0]  rd_plain
);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{mtype: 1'b1, priv: 1'b1, mode: 4'h0, inc: INC_OFF,
                       err: 1'b0, size: 3'b000};
            tar   <= '0;
        end else begin
            if (wr_en && addr == REG_AW'(OFS_CSW)) begin
                if (!busy) ctl_q.mtype <= wdata[29];
                ctl_q.priv <= wdata[25];
                ctl_q.mode <= wdata[11:8];
                ctl_q.inc  <= inc_e'(wdata[5:4]);
                ctl_q.size <= wdata[2:0];
                if (wdata[3]) ctl_q.err <= 1'b0;
            end
            if (wr_en && addr == REG_AW'(OFS_TAR)) tar <= wdata;
            if (tar_step) tar <= page_step(tar, ctl_q.size);
            if (err_set) ctl_q.err <= 1'b1;
        end
    end

    always_comb begin
        rd_plain = '0;
        if (addr == REG_AW'(OFS_CSW))      rd_plain = csw_word(ctl_q, busy, dbg_en);
        else if (addr == REG_AW'(OFS_TAR)) rd_plain = tar;
        else if (addr == REG_AW'(OFS_ROM)) rd_plain = ROM_WORD;
        else if (addr == REG_AW'(OFS_ID))  rd_plain = ID_WORD;
    end

    assign out_mtype = ctl_q.mtype;
    assign out_priv  = ctl_q.priv;
    assign out_inc   = ctl_q.inc;
    assign out_size  = ctl_q.size;

endmodule

// File: rtl/dbgab_xfer.sv
module dbgab_xfer
    import dbgab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             go_wr,
    input  logic             go_bank,
    input  logic [1:0]       go_idx,
    input  logic [BUS_W-1:0] go_wdata,
    input  logic [BUS_W-1:0] tar,
    input  inc_e             ctl_inc,
    input  logic [2:0]       ctl_size,
    input  logic             dbg_en,
    input  logic             hready,
    input  logic             hresp,
    input  logic [BUS_W-1:0] hrdata,
    output logic [1:0]       htrans,
    output logic [BUS_W-1:0] haddr,
    output logic             hwrite,
    output logic [2:0]       hsize,
    output logic [BUS_W-1:0] hwdata,
    output logic             resp,
    output logic [BUS_W-1:0] rdata,
    output logic             busy,
    output logic             tar_step,
    output logic             err_set
);

    xfer_st_e         st;
    logic [BUS_W-1:0] a_q;
    logic [BUS_W-1:0] wd_q;
    logic             wr_q;
    logic             step_q;
    logic [2:0]       sz_q;
    logic [BUS_W-1:0] op_addr;
    logic             allowed;
    logic             closing;

    assign op_addr = go_bank ? {tar[BUS_W-1:4], go_idx, 2'b00} : tar;
    assign allowed = dbg_en && (ctl_inc != INC_RSVD) && (ctl_size <= SZ_MAX);
    assign closing = (st == ST_DATA) && hready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            a_q    <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
            step_q <= 1'b0;
            sz_q   <= 3'b000;
            rdata  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    a_q    <= op_addr;
                    wr_q   <= go_wr;
                    sz_q   <= ctl_size;
                    wd_q   <= place_lanes(go_wdata, op_addr[1:0], ctl_size);
                    step_q <= !go_bank && (ctl_inc == INC_SINGLE || ctl_inc == INC_PACKED);
                    rdata  <= '0;
                    st     <= allowed ? ST_ADDR : ST_RESP;
                end
                ST_ADDR: if (hready) st <= ST_DATA;
                ST_DATA: if (hready) begin
                    st <= ST_RESP;
                    if (!wr_q && !hresp) rdata <= pick_lanes(hrdata, a_q[1:0], sz_q);
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign htrans   = (st == ST_ADDR) ? HT_NONSEQ : HT_IDLE;
    assign haddr    = a_q;
    assign hwrite   = wr_q;
    assign hsize    = sz_q;
    assign hwdata   = wd_q;
    assign resp     = (st == ST_RESP);
    assign busy     = (st != ST_IDLE);
    assign tar_step = closing && !hresp && step_q;
    assign err_set  = closing && hresp;

endmodule

// File: rtl/dbg_ahb_bridge.sv
module dbg_ahb_bridge
    import dbgab_pkg::*;
#(
    parameter int          REG_AW   = 8,
    parameter logic [31:0] ROM_WORD = 32'hE00F_F003,
    parameter logic [31:0] ID_WORD  = 32'h2477_0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_ready,
    output logic [31:0]       haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic [3:0]        hprot,
    output logic              hdebug,
    output logic [31:0]       hwdata,
    input  logic [31:0]       hrdata,
    input  logic              hready,
    input  logic              hresp
);

    logic             is_data;
    logic             is_bank;
    logic             is_drw;
    logic             accept;
    logic             plain_rdy_q;
    logic [BUS_W-1:0] plain_rd_q;
    logic [BUS_W-1:0] rd_plain;
    logic [BUS_W-1:0] tar_w;
    logic [BUS_W-1:0] x_rdata;
    logic             x_busy;
    logic             x_resp;
    logic             tar_step;
    logic             err_set;
    logic             c_mtype;
    logic             c_priv;
    inc_e             c_inc;
    logic [2:0]       c_size;

    assign is_drw  = (reg_addr == REG_AW'(OFS_DATA));
    assign is_bank = ({reg_addr[REG_AW-1:4], reg_addr[1:0]} == {(REG_AW-4)'(1), 2'b00});
    assign is_data = is_drw || is_bank;
    assign accept  = reg_sel && !x_busy && !plain_rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            plain_rdy_q <= 1'b0;
            plain_rd_q  <= '0;
        end else begin
            plain_rdy_q <= accept && !is_data;
            if (accept && !is_data) plain_rd_q <= reg_wr ? '0 : rd_plain;
        end
    end

    dbgab_regs #(
        .REG_AW  (REG_AW),
        .ROM_WORD(ROM_WORD),
        .ID_WORD (ID_WORD)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept && reg_wr && !is_data),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (x_busy),
        .dbg_en   (dbg_en),
        .tar_step (tar_step),
        .err_set  (err_set),
        .out_mtype(c_mtype),
        .out_priv (c_priv),
        .out_inc  (c_inc),
        .out_size (c_size),
        .tar      (tar_w),
        .rd_plain (rd_plain)
    );

    dbgab_xfer u_xfer (
        .clk     (clk),
        .rst     (rst),
        .go      (accept && is_data),
        .go_wr   (reg_wr),
        .go_bank (is_bank),
        .go_idx  (reg_addr[3:2]),
        .go_wdata(reg_wdata),
        .tar     (tar_w),
        .ctl_inc (c_inc),
        .ctl_size(c_size),
        .dbg_en  (dbg_en),
        .hready  (hready),
        .hresp   (hresp),
        .hrdata  (hrdata),
        .htrans  (htrans),
        .haddr   (haddr),
        .hwrite  (hwrite),
        .hsize   (hsize),
        .hwdata  (hwdata),
        .resp    (x_resp),
        .rdata   (x_rdata),
        .busy    (x_busy),
        .tar_step(tar_step),
        .err_set (err_set)
    );

    assign reg_ready = plain_rdy_q || x_resp;
    assign reg_rdata = plain_rdy_q ? plain_rd_q : x_rdata;
    assign hburst    = HB_SINGLE;
    assign hprot     = {2'b00, c_priv, 1'b1};
    assign hdebug    = c_mtype;

endmodule

// File: rtl/dbgab_checker.sv
module dbgab_checker #(
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_en,
    input logic              reg_ready,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              accept,
    input logic [1:0]        htrans,
    input logic [2:0]        hburst,
    input logic              hready,
    input logic [31:0]       haddr,
    input logic [31:0]       tar
);

    logic tar_load;
    assign tar_load = accept && reg_wr && (reg_addr == REG_AW'(8'h04));

    // R3: only NONSEQ single transfers appear on the bus
    a_r3_single_nonseq: assert property (@(posedge clk) disable iff (rst)
        (htrans != 2'b00) |-> (htrans == 2'b10 && hburst == 3'b000))
        else $error("a_r3_single_nonseq");

    // R3: address phase held while the slave stalls it
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr)))
        else $error("a_r3_addr_hold");

    // R10: no bus traffic without permission
    a_r10_gate: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b10) |-> dbg_en)
        else $error("a_r10_gate");

    // R12: ready is a single-cycle pulse
    a_r12_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_ready |=> !reg_ready)
        else $error("a_r12_ready_pulse");

    // R12: ready never overlaps an address phase
    a_r12_no_early_ready: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b10) |-> !reg_ready)
        else $error("a_r12_no_early_ready");

    // R7: page bits move only through a direct register load
    a_r7_page_fixed: assert property (@(posedge clk) disable iff (rst)
        !$past(tar_load) |-> (tar[31:12] == $past(tar[31:12])))
        else $error("a_r7_page_fixed");

endmodule

bind dbg_ahb_bridge dbgab_checker #(.REG_AW(REG_AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dbg_en   (dbg_en),
    .reg_ready(reg_ready),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .accept   (accept),
    .htrans   (htrans),
    .hburst   (hburst),
    .hready   (hready),
    .haddr    (haddr),
    .tar      (tar_w)
);

// File: tb/dbg_ahb_bridge_test.sv
`timescale 1ns/1ps
module dbg_ahb_bridge_test;

    localparam logic [7:0] A_CSW  = 8'h00;
    localparam logic [7:0] A_TAR  = 8'h04;
    localparam logic [7:0] A_DRW  = 8'h0C;
    localparam logic [7:0] A_ROM  = 8'hF8;
    localparam logic [7:0] A_ID   = 8'hFC;

    // {size, inc, tar, wdata, expected hwdata, expected tar afterwards}
    localparam int NV = 6;
    localparam logic [132:0] VEC [0:NV-1] = '{
        {3'd2, 2'd0, 32'h2000_0100, 32'h1122_3344, 32'h1122_3344, 32'h2000_0100},
        {3'd0, 2'd1, 32'h2000_0101, 32'h0000_00AB, 32'h0000_AB00, 32'h2000_0102},
        {3'd1, 2'd1, 32'h2000_0102, 32'h0000_BEEF, 32'hBEEF_0000, 32'h2000_0104},
        {3'd2, 2'd1, 32'h2000_0FFC, 32'hCAFE_F00D, 32'hCAFE_F00D, 32'h2000_0000},
        {3'd0, 2'd1, 32'h3000_1FFF, 32'h0000_0055, 32'h5500_0000, 32'h3000_1000},
        {3'd2, 2'd2, 32'h4000_0010, 32'h0000_0000, 32'h0000_0000, 32'h4000_0014}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_en = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [2:0]  hburst;
    logic [3:0]  hprot;
    logic        hdebug;
    logic [31:0] hwdata;
    logic [31:0] hrdata;
    logic        hready;
    logic        hresp;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] rd;
    int          lat;

    logic [31:0] slv_rdata = 32'h0;
    logic        slv_err = 1'b0;
    int          slv_waits = 0;
    int          s_cnt;
    logic [31:0] s_addr, s_write, s_size, s_burst, s_prot, s_mdbg, s_wdata;

    always #2 clk = ~clk;

    dbg_ahb_bridge uut (
        .clk(clk), .rst(rst), .dbg_en(dbg_en),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
        .hburst(hburst), .hprot(hprot), .hdebug(hdebug), .hwdata(hwdata),
        .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    // AHB slave model, acting on falling edges only.
    initial begin
        bit dph;
        bit fin;
        int wl;
        dph = 0; fin = 0; wl = 0;
        hready = 1'b1; hresp = 1'b0; hrdata = 32'h0; s_cnt = 0;
        s_addr = 0; s_write = 0; s_size = 0; s_burst = 0; s_prot = 0; s_mdbg = 0; s_wdata = 0;
        forever begin
            @(negedge clk);
            if (fin) begin
                hready = 1'b1; hresp = 1'b0; fin = 0;
            end
            if (dph) begin
                if (wl > 0) begin
                    wl--; hready = 1'b0;
                end else begin
                    hready = 1'b1; hresp = slv_err; hrdata = slv_rdata;
                    s_wdata = hwdata; dph = 0; fin = 1;
                end
            end else if (htrans == 2'b10 && hready) begin
                s_addr  = haddr;
                s_write = 32'(hwrite);
                s_size  = 32'(hsize);
                s_burst = 32'(hburst);
                s_prot  = 32'(hprot);
                s_mdbg  = 32'(hdebug);
                s_cnt++;
                dph = 1; wl = slv_waits;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = w; reg_addr = a; reg_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!reg_ready && lat < 40);
        rd = reg_rdata;
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wrap_up();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset value and R12 plain latency
        acc(0, A_CSW, 0);
        chk("R2 reset csw", rd, 32'h2300_0040);
        chk("R12 plain latency", 32'(lat), 32'd1);
        acc(0, A_TAR, 0);
        chk("R1 tar reset", rd, 32'h0);

        // R1 map
        acc(0, A_ROM, 0);  chk("R1 rom word", rd, 32'hE00F_F003);
        acc(0, A_ID, 0);   chk("R1 id word", rd, 32'h2477_0011);
        acc(0, 8'h08, 0);  chk("R1 hole 08", rd, 32'h0);
        acc(0, 8'h20, 0);  chk("R1 hole 20", rd, 32'h0);
        acc(1, A_ID, 32'hFFFF_FFFF);
        acc(0, A_ID, 0);   chk("R1 id write ignored", rd, 32'h2477_0011);

        // Table walk: R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  sz;
            logic [1:0]  inc;
            logic [31:0] t, wd, hw, tn;
            {sz, inc, t, wd, hw, tn} = VEC[i];
            acc(1, A_CSW, 32'h2200_0000 | 32'({inc, 1'b0, sz}));
            acc(1, A_TAR, t);
            c0 = s_cnt;
            acc(1, A_DRW, wd);
            chk("R3 one transfer", 32'(s_cnt - c0), 32'd1);
            chk("R3 hwrite", s_write, 32'd1);
            chk("R3 haddr", s_addr, t);
            chk("R3 hsize", s_size, 32'(sz));
            chk("R3 hburst", s_burst, 32'd0);
            chk("R4 hwdata lanes", s_wdata, hw);
            acc(0, A_TAR, 0);
            chk("R6 R7 tar after", rd, tn);
        end

        // R5 read lanes and R12 bus latency
        acc(1, A_CSW, 32'h2200_0000);
        acc(1, A_TAR, 32'h7000_0003);
        slv_rdata = 32'h9A00_0000;
        acc(0, A_DRW, 0);
        chk("R5 byte lane 3", rd, 32'h0000_009A);
        chk("R3 read hwrite", s_write, 32'd0);
        chk("R12 bus latency", 32'(lat), 32'd3);
        acc(1, A_CSW, 32'h2200_0001);
        acc(1, A_TAR, 32'h7000_0002);
        slv_rdata = 32'h1234_5678;
        acc(0, A_DRW, 0);
        chk("R5 upper half", rd, 32'h0000_1234);

        // R12 wait states
        acc(1, A_CSW, 32'h2200_0002);
        slv_waits = 3; slv_rdata = 32'hDEAD_BEEF;
        acc(0, A_DRW, 0);
        chk("R12 wait latency", 32'(lat), 32'd6);
        chk("R5 word read", rd, 32'hDEAD_BEEF);
        slv_waits = 0;

        // R8 error
        acc(1, A_CSW, 32'h2200_0012);
        acc(1, A_TAR, 32'h6000_0000);
        slv_err = 1'b1;
        c0 = s_cnt;
        acc(1, A_DRW, 32'h1);
        slv_err = 1'b0;
        chk("R8 transfer issued", 32'(s_cnt - c0), 32'd1);
        acc(0, A_CSW, 0);  chk("R8 error sticky", rd, 32'h2300_005A);
        acc(0, A_TAR, 0);  chk("R8 no increment", rd, 32'h6000_0000);
        acc(0, A_CSW, 0);  chk("R8 still set", rd, 32'h2300_005A);
        acc(1, A_CSW, 32'h2200_001A);
        acc(0, A_CSW, 0);  chk("R8 cleared", rd, 32'h2300_0052);

        // R9 banked windows
        acc(1, A_TAR, 32'h5000_0123);
        slv_rdata = 32'h0BAD_F00D;
        acc(0, 8'h18, 0);
        chk("R9 bank2 addr", s_addr, 32'h5000_0128);
        chk("R9 bank2 data", rd, 32'h0BAD_F00D);
        acc(1, 8'h14, 32'h0000_0011);
        chk("R9 bank1 addr", s_addr, 32'h5000_0124);
        chk("R9 bank1 wdata", s_wdata, 32'h0000_0011);
        acc(0, A_TAR, 0);
        chk("R9 tar unchanged", rd, 32'h5000_0123);

        // R10 permission
        @(negedge clk); dbg_en = 1'b0;
        acc(0, A_CSW, 0);  chk("R10 bit6 low", rd, 32'h2300_0012);
        c0 = s_cnt;
        acc(1, A_DRW, 32'h5);
        slv_rdata = 32'hFFFF_FFFF;
        acc(0, A_DRW, 0);
        chk("R10 read zero", rd, 32'h0);
        chk("R10 no transfer", 32'(s_cnt - c0), 32'd0);
        chk("R10 latency", 32'(lat), 32'd1);
        acc(0, A_TAR, 0);  chk("R10 tar unchanged", rd, 32'h5000_0123);
        @(negedge clk); dbg_en = 1'b1;

        // R2 reserved bits and R11 suppression
        acc(1, A_CSW, 32'hFFFF_FFF7);
        acc(0, A_CSW, 0);  chk("R2 reserved bits", rd, 32'h2300_0F77);
        c0 = s_cnt;
        acc(1, A_DRW, 32'h7);
        chk("R11 inc 11 no transfer", 32'(s_cnt - c0), 32'd0);
        acc(1, A_CSW, 32'h2200_0003);
        acc(0, A_DRW, 0);
        chk("R11 size 011 no transfer", 32'(s_cnt - c0), 32'd0);
        chk("R11 read zero", rd, 32'h0);

        // R13 protection and master type, R2 mode field
        acc(1, A_CSW, 32'h0000_0002);
        acc(0, A_CSW, 0);  chk("R13 csw readback", rd, 32'h0100_0042);
        acc(1, A_DRW, 32'h9);
        chk("R13 hprot user", s_prot, 32'h1);
        chk("R13 core master", s_mdbg, 32'h0);
        acc(1, A_CSW, 32'h2200_0A02);
        acc(0, A_CSW, 0);  chk("R2 mode field", rd, 32'h2300_0A42);
        acc(1, A_DRW, 32'h9);
        chk("R13 hprot priv", s_prot, 32'h3);
        chk("R13 debug master", s_mdbg, 32'h1);

        repeat (4) @(negedge clk);
        wrap_up();
    end

endmodule